// File: doc/BRIEF.md
# Fixed-Latency Word Delay Line

This block delays a stream of words by a fixed number of clock cycles, set by the parameter `LENGTH`. A word is taken on every rising clock edge. The same word comes out, unchanged, `LENGTH` register stages later. It is meant for pipelines where a value has to wait beside a long datapath: a message schedule, a tag or a counter copy that must line up with results computed many cycles later.

By default (`USE_RAM = 1`), the storage is a ring of `LENGTH-1` words indexed by one rotating pointer. At each pointer position a registered read takes the old word, and the incoming word replaces it in the same cycle. The registered read output is the final delay stage, so the whole ring can map to a block memory with its output register. With `USE_RAM = 0`, the block is built instead as a chain of `LENGTH` word-wide flip-flop stages, which makes it easy to compare area and timing. Both variants behave the same at the ports.

The stream has no valid/ready handshake. The line accepts a word on every cycle and cannot apply back-pressure. A producer that sometimes has no data should keep driving a filler word, because every cycle counts toward the delay. There is no reset. The pointer powers up at zero. The output carries meaningful data only once `LENGTH` words have been taken in.

Top module: `word_delay_line`

## Requirements
- R1: With `USE_RAM = 1`, the word on `dout` just after clock edge k equals the word on `din` at edge k-LENGTH+1, which is LENGTH register stages. This holds for every k at or after LENGTH-1, counting the first edge as 0.
- R2: With `USE_RAM = 0`, the same timing as R1 holds, so for an identical input stream both variants give bit-identical `dout`.
- R3: In the ring variant, the write/read pointer starts at 0 and advances by exactly one each clock. After reaching LENGTH-2 it goes back to 0.
- R4: In the ring variant, the pointer never leaves the range 0 to LENGTH-2, which is the LENGTH-1 entries of the ring.
- R5: If `din` holds the same word at LENGTH consecutive edges, `dout` shows that word after the last of them.
- R6: The smallest length, LENGTH = 2, gives a one-entry ring plus the output register and still meets R1 and R2.
- R7: A word is taken on every clock with no stall, and all WIDTH bits pass through unchanged. This includes all-zeros, all-ones and alternating 0x55555555 / 0xAAAAAAAA words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one word is taken per edge |
| din | input | WIDTH | Word entering the line |
| dout | output | WIDTH | Word that entered LENGTH stages earlier |

## Verification
The hardest case to reach is a pointer that has just wrapped. Here the ring entry being read is the one written LENGTH-1 cycles before, so an off-by-one in the wrap point or in the read-before-write ordering would return a word that is one cycle too new or too old. The stimulus drives a fresh word on every cycle, mostly from a seeded random source. It runs for many wrap periods at lengths 2, 3, 8 and 17, with both variants side by side on the same input. Directed holds of a constant word and alternating bit patterns are mixed in, so that a wrong wrap shows up as a mismatch against a reference queue and not as a coincidence of equal words.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Width of an index into a ring of the given number of entries (at least 1 bit).
  function automatic int ring_index_width(input int entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction
endpackage

// File: rtl/dly_ring_ptr.sv
module dly_ring_ptr #(
  parameter int ENTRIES = 7,
  parameter int PTR_W   = 3
) (
  input  logic             clk,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptr_q = '0;

  always_ff @(posedge clk) begin
    if (ptr_q == LAST_IDX) ptr_q <= '0;
    else                   ptr_q <= ptr_q + PTR_W'(1);
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dly_ring_mem.sv
module dly_ring_mem #(
  parameter int ENTRIES = 7,
  parameter int WIDTH   = 32,
  parameter int PTR_W   = 3
) (
  input  logic             clk,
  input  logic [PTR_W-1:0] idx,
  input  logic [WIDTH-1:0] wr_word,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] cells [ENTRIES];
  logic [WIDTH-1:0] rd_q;

  // Registered read of the old cell, then overwrite: read-before-write port.
  always_ff @(posedge clk) begin
    rd_q       <= cells[idx];
    cells[idx] <= wr_word;
  end

  assign rd_word = rd_q;
endmodule

// File: rtl/dly_ff_chain.sv
module dly_ff_chain #(
  parameter int STAGES = 8,
  parameter int WIDTH  = 32
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d_in;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/word_delay_line.sv
module word_delay_line #(
  parameter int LENGTH  = 8,
  parameter int WIDTH   = 32,
  parameter bit USE_RAM = 1'b1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int RING_ENTRIES = LENGTH - 1;
  localparam int PTR_W        = dly_pkg::ring_index_width(RING_ENTRIES);

  logic [PTR_W-1:0] ring_ptr;

  if (USE_RAM) begin : g_ring
    dly_ring_ptr #(.ENTRIES(RING_ENTRIES), .PTR_W(PTR_W)) i_ptr (
      .clk (clk),
      .ptr (ring_ptr)
    );
    dly_ring_mem #(.ENTRIES(RING_ENTRIES), .WIDTH(WIDTH), .PTR_W(PTR_W)) i_mem (
      .clk     (clk),
      .idx     (ring_ptr),
      .wr_word (din),
      .rd_word (dout)
    );
  end else begin : g_chain
    assign ring_ptr = '0;
    dly_ff_chain #(.STAGES(LENGTH), .WIDTH(WIDTH)) i_chain (
      .clk   (clk),
      .d_in  (din),
      .d_out (dout)
    );
  end
endmodule

// File: rtl/word_delay_line_chk.sv
module word_delay_line_chk #(
  parameter int LENGTH  = 8,
  parameter int WIDTH   = 32,
  parameter bit USE_RAM = 1'b1
) (
  input logic                 clk,
  input logic [WIDTH-1:0]     din,
  input logic [WIDTH-1:0]     dout,
  input logic [dly_pkg::ring_index_width(LENGTH-1)-1:0] ring_ptr
);
  localparam int PTR_W = dly_pkg::ring_index_width(LENGTH - 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(LENGTH - 2);

  logic             warm      = 1'b0;
  logic [WIDTH-1:0] last_din  = '0;
  int unsigned      hold_run  = 0;

  // Counts consecutive edges on which din carried the same word.
  always_ff @(posedge clk) begin
    warm     <= 1'b1;
    last_din <= din;
    if (warm && din == last_din) begin
      if (hold_run < 32'hFFFF_0000) hold_run <= hold_run + 1;
    end else begin
      hold_run <= 1;
    end
  end

  if (USE_RAM) begin : g_ring_props
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!warm)
      (ring_ptr != LAST_IDX) |=> (ring_ptr == $past(ring_ptr) + PTR_W'(1)));
    assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!warm)
      (ring_ptr == LAST_IDX) |=> (ring_ptr == '0));
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!warm)
      ring_ptr <= LAST_IDX);
  end

  assert_hold_passes_R5: assert property (@(posedge clk) disable iff (!warm)
    (hold_run >= LENGTH) |-> (dout == last_din));
endmodule

bind word_delay_line word_delay_line_chk #(
  .LENGTH(LENGTH), .WIDTH(WIDTH), .USE_RAM(USE_RAM)
) i_word_delay_line_chk (
  .clk(clk), .din(din), .dout(dout), .ring_ptr(ring_ptr)
);

// File: tb/test_word_delay_line.sv
module test_word_delay_line;
  localparam int W     = 32;
  localparam int NCFG  = 8;
  localparam int HIST  = 32;

  logic          clk = 1'b0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout_a [NCFG];

  int tests_run = 0;
  int tests_bad = 0;
  int steps     = 0;
  logic [W-1:0] hist [HIST];

  always #2.5 clk = ~clk;

  function automatic int cfg_len(input int g);
    case (g % 4)
      0: return 2;
      1: return 3;
      2: return 8;
      default: return 17;
    endcase
  endfunction

  function automatic bit cfg_ram(input int g);
    return g < 4;
  endfunction

  for (genvar g = 0; g < NCFG; g++) begin : g_dut
    word_delay_line #(
      .LENGTH(cfg_len(g)), .WIDTH(W), .USE_RAM(cfg_ram(g))
    ) i_word_delay_line (
      .clk(clk), .din(din), .dout(dout_a[g])
    );
  end

  function automatic string req_tag(input int g);
    if (cfg_len(g) == 2) return cfg_ram(g) ? "R6 R1" : "R6 R2";
    return cfg_ram(g) ? "R1 R3 R4" : "R2";
  endfunction

  task automatic check_word(input string tag, input int g, input logic [W-1:0] got,
                            input logic [W-1:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_bad++;
      $display("FAIL %s len=%0d ram=%0d step=%0d got=%08h exp=%08h",
               tag, cfg_len(g), cfg_ram(g), steps, got, exp);
    end
  endtask

  // One clock: drive at negedge, sample 1 ns after the rising edge.
  task automatic step(input logic [W-1:0] word, input string extra);
    @(negedge clk);
    din = word;
    @(posedge clk);
    #1;
    for (int k = HIST-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = word;
    steps++;
    for (int g = 0; g < NCFG; g++) begin
      if (steps >= cfg_len(g))
        check_word({req_tag(g), extra}, g, dout_a[g], hist[cfg_len(g)-1]);
    end
  endtask

  initial begin
    #1_000_000;
    tests_run++;
    tests_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    for (int k = 0; k < HIST; k++) hist[k] = '0;
    // Start-up: distinct words so the first valid output of each length is checked.
    for (int n = 0; n < 20; n++) step(32'h1000_0000 + n, "");
    // Random stream across many pointer wraps (R3 R4 via wrap-sensitive data).
    for (int n = 0; n < 600; n++) step($urandom(seed), "");
    // Constant hold longer than the largest length (R5).
    for (int n = 0; n < 20; n++) step(32'hC0FF_EE11, " R5");
    for (int g = 0; g < NCFG; g++) check_word("R5 hold", g, dout_a[g], 32'hC0FF_EE11);
    // Bit patterns, every cycle, no stall (R7).
    for (int n = 0; n < 40; n++) step((n % 2) ? 32'hAAAA_AAAA : 32'h5555_5555, " R7");
    for (int n = 0; n < 20; n++) step((n % 3 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000, " R7");
    // Both variants agree word for word (R2).
    for (int n = 0; n < 100; n++) begin
      step($urandom(seed), "");
      for (int g = 0; g < 4; g++) check_word("R2 equal", g + 4, dout_a[g + 4], dout_a[g]);
    end
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_bad);
    $finish;
  end
endmodule